// File: doc/BRIEF.md
# Video-Clock Serial Configuration Streamer

This block sends the contents of a display's configuration memory one way, over an open-drain data line, with no request from the other end. A slow video-rate clock paces it, and that clock arrives asynchronously to the system clock. The block starts up silent. It lets a fixed number of video-clock rising edges pass while the line stays released. It then sends bytes from address zero upward, most significant bit first. After each byte comes one filler bit, and during that bit the line is left released.

Only the lower half of the memory is sent. The read address wraps back to zero after the last byte of that half. A separate mode controller owns the enable input. Dropping the enable hands the data line to the controller's two-wire command path. Raising it again restarts the stream at byte zero without a second silent window.

The memory is read through a plain address/data port. The address moves to the next byte at the moment the filler bit goes out. The memory therefore has a whole video-clock period to return the next byte.

Top module: `edid_vclk_streamer`

## Requirements
- R1: While reset is asserted and just after it is released, `sda_drive_low` is 0 and `rd_addr` is 0.
- R2: The first 9 video-clock rising edges seen while enabled leave `sda_drive_low` at 0.
- R3: The 10th enabled rising edge presents bit 7 of byte 0. After that, each rising edge presents the next bit. The line changes only after a synchronised rising edge, or when the enable changes.
- R4: Data bits go out in the order bit 7 down to bit 0. A data bit of 0 sets `sda_drive_low` to 1, and a data bit of 1 sets it to 0.
- R5: The edge after bit 0 of each byte presents a filler bit, with `sda_drive_low` at 0.
- R6: `rd_addr` counts 0,1,…,127,0 and moves forward on the edge that presents the filler bit. Bit 7 of `rd_addr` is always 0.
- R7: While `stream_en` is 0, `sda_drive_low` is 0 and `rd_addr` is 0. Video-clock edges have no effect on either output.
- R8: After `stream_en` returns to 1, the next rising edge presents bit 7 of byte 0. No new silent window is inserted.
- R9: Rising edges that arrive while `stream_en` is 0 do not count toward the 9 edges of the start-up window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vclk_in | input | 1 | Video-rate clock, asynchronous to `clk` |
| stream_en | input | 1 | Enable from the mode controller; 0 hands the line away |
| rd_data | input | 8 | Byte returned by the memory for `rd_addr` |
| rd_addr | output | 8 | Memory read address |
| sda_drive_low | output | 1 | 1 pulls the open-drain data line low |

## Verification
The checks assume that each video-clock level lasts several system clocks. With that spacing, the two-stage synchroniser produces exactly one rise strobe per edge. The checks also assume that `rd_data` follows `rd_addr` within one video-clock period. The stimulus meets both conditions: it holds each clock level for six system cycles and models the memory as a combinational function of the address. The enable changes only while the video clock is low and settled, so it never lands in the same cycle as a rise strobe.

// File: rtl/edid_stream_pkg.sv
package edid_stream_pkg;

   // Width of a bit counter that can hold one byte position plus the filler slot
   function automatic int slot_width(input int data_w);
      return $clog2(data_w + 1);
   endfunction

   // Width needed to count up to a given number of warm-up edges
   function automatic int count_width(input int edges);
      return (edges < 2) ? 1 : $clog2(edges + 1);
   endfunction

endpackage

// File: rtl/vclk_edge_sync.sv
module vclk_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vclk_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/warmup_gate.sv
module warmup_gate
   import edid_stream_pkg::*;
#(
   parameter int EDGES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rise,
   output logic done
);

   localparam int CW = count_width(EDGES);
   localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

   logic [CW-1:0] seen_q;

   generate
      if (EDGES < 1) begin : g_bad_edges
         $error("warmup_gate: EDGES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         done   <= 1'b0;
      end else if (en && rise && !done) begin
         seen_q <= seen_q + 1'b1;
         if (seen_q == LAST) done <= 1'b1;
      end
   end

endmodule

// File: rtl/byte_serializer.sv
module byte_serializer
   import edid_stream_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int STREAM_AW = 7,
   parameter int SW        = slot_width(DATA_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 rise,
   input  logic                 armed,
   input  logic [DATA_W-1:0]    rd_data,
   output logic [STREAM_AW-1:0] stream_addr,
   output logic [SW-1:0]        slot,
   output logic                 presenting,
   output logic                 drive_low
);

   localparam logic [SW-1:0] LAST_DATA = SW'(DATA_W - 1);
   localparam logic [SW-1:0] FILL_SLOT = SW'(DATA_W);

   logic [SW-1:0]     next_slot;
   logic [DATA_W-1:0] aligned;

   assign next_slot = slot + 1'b1;
   assign aligned   = rd_data << next_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stream_addr <= '0;
         slot        <= '0;
         presenting  <= 1'b0;
         drive_low   <= 1'b0;
      end else if (!en) begin
         stream_addr <= '0;
         slot        <= '0;
         presenting  <= 1'b0;
         drive_low   <= 1'b0;
      end else if (rise && armed) begin
         if (!presenting) begin
            presenting <= 1'b1;
            slot       <= '0;
            drive_low  <= ~rd_data[DATA_W-1];
         end else if (slot == LAST_DATA) begin
            slot        <= FILL_SLOT;
            drive_low   <= 1'b0;
            stream_addr <= stream_addr + 1'b1;
         end else if (slot == FILL_SLOT) begin
            slot      <= '0;
            drive_low <= ~rd_data[DATA_W-1];
         end else begin
            slot      <= next_slot;
            drive_low <= ~aligned[DATA_W-1];
         end
      end
   end

endmodule

// File: rtl/edid_vclk_streamer.sv
module edid_vclk_streamer
   import edid_stream_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int MEM_AW       = 8,
   parameter int STREAM_DEPTH = 128,
   parameter int WARM_EDGES   = 9,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vclk_in,
   input  logic              stream_en,
   input  logic [DATA_W-1:0] rd_data,
   output logic [MEM_AW-1:0] rd_addr,
   output logic              sda_drive_low
);

   localparam int STREAM_AW = (STREAM_DEPTH < 2) ? 1 : $clog2(STREAM_DEPTH);
   localparam int SW        = slot_width(DATA_W);

   generate
      if ((1 << STREAM_AW) != STREAM_DEPTH) begin : g_bad_depth
         $error("edid_vclk_streamer: STREAM_DEPTH must be a power of two");
      end
      if (STREAM_AW > MEM_AW) begin : g_bad_aw
         $error("edid_vclk_streamer: streamed region exceeds memory");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("edid_vclk_streamer: DATA_W must be at least 2");
      end
   endgenerate

   logic                 vclk_rise;
   logic                 warm_done;
   logic [STREAM_AW-1:0] stream_addr;
   logic [SW-1:0]        bit_slot;
   logic                 presenting;

   vclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (vclk_in),
      .rise     (vclk_rise)
   );

   warmup_gate #(.EDGES(WARM_EDGES)) u_warm (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (stream_en),
      .rise  (vclk_rise),
      .done  (warm_done)
   );

   byte_serializer #(
      .DATA_W    (DATA_W),
      .STREAM_AW (STREAM_AW),
      .SW        (SW)
   ) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (stream_en),
      .rise        (vclk_rise),
      .armed       (warm_done),
      .rd_data     (rd_data),
      .stream_addr (stream_addr),
      .slot        (bit_slot),
      .presenting  (presenting),
      .drive_low   (sda_drive_low)
   );

   generate
      if (STREAM_AW == MEM_AW) begin : g_addr_full
         assign rd_addr = stream_addr;
      end else begin : g_addr_pad
         assign rd_addr = {{(MEM_AW-STREAM_AW){1'b0}}, stream_addr};
      end
   endgenerate

endmodule

// File: rtl/edid_vclk_streamer_chk.sv
module edid_vclk_streamer_chk #(
   parameter int DATA_W       = 8,
   parameter int MEM_AW       = 8,
   parameter int STREAM_DEPTH = 128,
   parameter int SW           = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stream_en,
   input logic [MEM_AW-1:0] rd_addr,
   input logic              sda_drive_low,
   input logic              vclk_rise,
   input logic              warm_done,
   input logic              presenting,
   input logic [SW-1:0]     bit_slot
);

   localparam logic [MEM_AW-1:0] WRAP_MASK = MEM_AW'(STREAM_DEPTH - 1);
   localparam logic [SW-1:0]     FILL_SLOT = SW'(DATA_W);

   // R2: silent while the start-up window is still open
   a_r2_quiet_warmup: assert property (@(posedge clk) disable iff (!rst_n)
      !warm_done |-> !sda_drive_low);

   // R7: the line is released one cycle after the enable is low
   a_r7_released_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !stream_en |=> !sda_drive_low);

   // R7: the address returns to zero while disabled
   a_r7_addr_home_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !stream_en |=> (rd_addr == '0));

   // R3: the output moves only after a synchronised rising edge
   a_r3_moves_on_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_en && $past(stream_en) && !$past(vclk_rise)) |-> $stable(sda_drive_low));

   // R6: the address steps by one within the streamed half and wraps
   a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_en && $past(stream_en) && (rd_addr != $past(rd_addr)))
         |-> (rd_addr == (($past(rd_addr) + 1'b1) & WRAP_MASK)));

   // R5: the filler slot leaves the line released
   a_r5_filler_released: assert property (@(posedge clk) disable iff (!rst_n)
      (presenting && bit_slot == FILL_SLOT) |-> !sda_drive_low);

endmodule

bind edid_vclk_streamer edid_vclk_streamer_chk #(
   .DATA_W       (DATA_W),
   .MEM_AW       (MEM_AW),
   .STREAM_DEPTH (STREAM_DEPTH),
   .SW           (SW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stream_en     (stream_en),
   .rd_addr       (rd_addr),
   .sda_drive_low (sda_drive_low),
   .vclk_rise     (vclk_rise),
   .warm_done     (warm_done),
   .presenting    (presenting),
   .bit_slot      (bit_slot)
);

// File: tb/test_edid_vclk_streamer.sv
module test_edid_vclk_streamer;

   localparam int DATA_W = 8;
   localparam int MEM_AW = 8;
   localparam int DEPTH  = 128;
   localparam int WARM   = 9;
   localparam int HOLD   = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              vclk_in = 1'b0;
   logic              stream_en = 1'b1;
   logic [DATA_W-1:0] rd_data;
   logic [MEM_AW-1:0] rd_addr;
   logic              sda_drive_low;

   always #4 clk = ~clk;

   edid_vclk_streamer i_edid_vclk_streamer (
      .clk           (clk),
      .rst_n         (rst_n),
      .vclk_in       (vclk_in),
      .stream_en     (stream_en),
      .rd_data       (rd_data),
      .rd_addr       (rd_addr),
      .sda_drive_low (sda_drive_low)
   );

   function automatic logic [7:0] mem_byte(input logic [MEM_AW-1:0] a);
      return 8'((int'(a) * 37 + 8'h5C) & 8'hFF);
   endfunction

   assign rd_data = mem_byte(rd_addr);

   int n_cmp = 0;
   int n_bad = 0;

   // Expected-state model built from the requirements
   int ref_warm, ref_addr, ref_slot;
   bit ref_on, ref_low;

   // Vector table: [15] enable, [14:8] edge count, [3:0] requirement id
   localparam int NVEC = 7;
   localparam logic [15:0] VEC [0:NVEC-1] = '{
      {1'b1, 7'd9,  4'b0, 4'd2},
      {1'b1, 7'd1,  4'b0, 4'd3},
      {1'b1, 7'd8,  4'b0, 4'd4},
      {1'b1, 7'd19, 4'b0, 4'd5},
      {1'b0, 7'd4,  4'b0, 4'd7},
      {1'b1, 7'd12, 4'b0, 4'd8},
      {1'b1, 7'd20, 4'b0, 4'd6}
   };

   function automatic string tag_of(input int id);
      case (id)
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      logic [7:0] b;
      if (!stream_en) return;
      if (ref_warm < WARM) begin
         ref_warm++;
         ref_low = 1'b0;
      end else if (!ref_on) begin
         ref_on = 1'b1; ref_slot = 0;
         b = mem_byte(MEM_AW'(ref_addr));
         ref_low = ~b[7];
      end else if (ref_slot == DATA_W - 1) begin
         ref_slot = DATA_W; ref_low = 1'b0;
         ref_addr = (ref_addr + 1) % DEPTH;
      end else if (ref_slot == DATA_W) begin
         ref_slot = 0;
         b = mem_byte(MEM_AW'(ref_addr));
         ref_low = ~b[7];
      end else begin
         ref_slot++;
         b = mem_byte(MEM_AW'(ref_addr));
         ref_low = ~b[7 - ref_slot];
      end
   endtask

   task automatic pulse(input string tag);
      @(negedge clk) vclk_in = 1'b1;
      repeat (HOLD) @(negedge clk);
      model_step();
      check(tag, "sda_drive_low", int'(sda_drive_low), int'(ref_low));
      check(tag, "rd_addr", int'(rd_addr), ref_addr);
      vclk_in = 1'b0;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic set_en(input bit v);
      @(negedge clk) stream_en = v;
      if (!v) begin
         ref_on = 1'b0; ref_addr = 0; ref_slot = 0; ref_low = 1'b0;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic do_reset(input bit en_v);
      @(negedge clk);
      rst_n = 1'b0; vclk_in = 1'b0; stream_en = en_v;
      ref_warm = 0; ref_addr = 0; ref_slot = 0; ref_on = 1'b0; ref_low = 1'b0;
      repeat (4) @(negedge clk);
      check("R1", "sda_drive_low in reset", int'(sda_drive_low), 0);
      check("R1", "rd_addr in reset", int'(rd_addr), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "sda_drive_low after reset", int'(sda_drive_low), 0);
      check("R1", "rd_addr after reset", int'(rd_addr), 0);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      do_reset(1'b1);

      // Table walk: warm-up, first bit, data order, filler, disable, resume
      for (int v = 0; v < NVEC; v++) begin
         if (VEC[v][15] != stream_en) set_en(VEC[v][15]);
         for (int p = 0; p < int'(VEC[v][14:8]); p++) pulse(tag_of(int'(VEC[v][3:0])));
      end

      // R7: edges while disabled leave both outputs at rest
      set_en(1'b0);
      for (int p = 0; p < 3; p++) pulse("R7");
      check("R7", "rd_addr held at zero", int'(rd_addr), 0);
      check("R7", "line released", int'(sda_drive_low), 0);

      // R8: resume gives byte 0 bit 7 on the first edge
      set_en(1'b1);
      pulse("R8");
      check("R8", "first bit after resume", int'(sda_drive_low), int'(~mem_byte('0) >> 7) & 1);

      // R6: full pass over the streamed half, including the wrap to zero
      do_reset(1'b1);
      for (int p = 0; p < WARM; p++) pulse("R2");
      for (int p = 0; p < DEPTH * (DATA_W + 1) + 1; p++) pulse("R6");
      check("R6", "address after wrap", int'(rd_addr), 0);
      check("R6", "top address bit", int'(rd_addr[MEM_AW-1]), 0);

      // R9: edges while disabled do not shorten the start-up window
      do_reset(1'b0);
      for (int p = 0; p < 5; p++) pulse("R9");
      set_en(1'b1);
      for (int p = 0; p < WARM; p++) pulse("R9");
      check("R9", "still silent after window", int'(sda_drive_low), 0);
      pulse("R9");
      check("R9", "byte 0 bit 7 after window", int'(sda_drive_low),
            int'(~mem_byte('0) >> 7) & 1);

      summary();
      $finish;
   end

endmodule